// File: doc/BRIEF.md
# Parallel Display Write Port

This block puts single bytes onto an 8-bit parallel bus that feeds an external display controller. A requester hands over one byte with a flag. The flag says whether the byte is a register index (a command) or a parameter for the most recent index. The block then runs the whole bus transfer on its own. It lowers chip select and write together and sets register-select from the flag. It drives the byte, then raises write and chip select again. Every step is held for a fixed number of clock cycles, so the device's set-up and hold times are met.

The requester uses a valid/ready pair. A byte is taken on a clock edge where both are high. Ready then stays low until the closing step has run its full length. A one-cycle done pulse marks the moment the bus is idle again. The read strobe is never used, and it stays inactive.

Top module: `dpw_port`

## Requirements
- R1: While reset is asserted and right after it, chip select, read, write and register-select are all high, the data bus is zero, ready is high and done is low.
- R2: The control nibble {cs_n, rd_n, wr_n, rs} (bit 3 down to bit 0) for an index transfer (flag low) is 4'b0100 during the open and drive steps and 4'b1110 during the close step.
- R3: For a parameter transfer (flag high) the control nibble is 4'b0101 during the open and drive steps and 4'b1111 during the close step.
- R4: The read strobe rd_n is high at all times.
- R5: After the accepting edge, three steps follow in order, each lasting HOLD_CYC cycles. In the open step the control opens and the data bus keeps its previous value. In the drive step the new byte appears on the data bus. In the close step the control closes.
- R6: The data bus keeps the byte through the release of chip select and afterwards, until a later transfer drives a new byte.
- R7: Ready is low from the cycle after acceptance until the close step has finished. A request presented while ready is low is ignored and changes no output.
- R8: Done is high for exactly one cycle, in the first cycle in which ready is high again after a transfer.
- R9: When no request is accepted the outputs stay unchanged: control stays at the last closing value and done stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_byte | input | DATA_W | Byte to send |
| req_is_param | input | 1 | 1 = parameter byte, 0 = register index |
| bus_data | output | DATA_W | Parallel data bus to the device |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low, held inactive |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rs | output | 1 | Register-select: low for index, high for parameter |
| xfer_done | output | 1 | One-cycle pulse when a transfer completes |

## Verification
The assertions assume the requester obeys the handshake. That means req_byte and req_is_param only matter on the accepting edge, and a request is counted only when ready is high. The stimulus drives all inputs on the falling clock edge. It lowers valid on the first falling edge after acceptance. It also raises a stray request in the middle of a transfer and withdraws it before the block is idle again. This shows that a request seen while busy is ignored, and it never leaves a request pending across the return to idle.

// File: rtl/dpw_pkg.sv
package dpw_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_OPEN  = 2'd1,
        PH_DRIVE = 2'd2,
        PH_CLOSE = 2'd3
    } phase_e;

    // Control nibble, MSB first: chip select, read, write, register-select
    typedef struct packed {
        logic cs_n;
        logic rd_n;
        logic wr_n;
        logic rs;
    } ctrl_t;

endpackage

// File: rtl/dpw_hold_timer.sv
module dpw_hold_timer #(
    parameter int HOLD_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expire
);
    localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (restart)  cnt_d = '0;
        else if (run) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == LAST);
endmodule

// File: rtl/dpw_ctrl_enc.sv
module dpw_ctrl_enc
    import dpw_pkg::*;
(
    input  phase_e phase,
    input  logic   rs,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl.rd_n = 1'b1;      // no reads are ever issued
        ctrl.rs   = rs;
        case (phase)
            PH_OPEN, PH_DRIVE: begin
                ctrl.cs_n = 1'b0;
                ctrl.wr_n = 1'b0;
            end
            default: begin
                ctrl.cs_n = 1'b1;
                ctrl.wr_n = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/dpw_port.sv
module dpw_port
    import dpw_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int HOLD_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_byte,
    input  logic              req_is_param,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_rs,
    output logic              xfer_done
);
    typedef struct packed {
        phase_e            phase;
        logic              rs;
        logic [DATA_W-1:0] held;
        logic [DATA_W-1:0] data;
        logic              done;
    } state_t;

    localparam ctrl_t CTRL_RST = '{cs_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1, rs: 1'b1};

    state_t st_d, st_q;
    ctrl_t  ctrl_d, ctrl_q;
    logic   accept, expire, restart, run;

    assign accept  = req_valid && (st_q.phase == PH_IDLE);
    assign run     = (st_q.phase != PH_IDLE);
    assign restart = accept || (run && expire);

    dpw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .expire  (expire)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        case (st_q.phase)
            PH_IDLE: if (accept) begin
                st_d.phase = PH_OPEN;
                st_d.rs    = req_is_param;
                st_d.held  = req_byte;
            end
            PH_OPEN: if (expire) begin
                st_d.phase = PH_DRIVE;
                st_d.data  = st_q.held;
            end
            PH_DRIVE: if (expire) st_d.phase = PH_CLOSE;
            PH_CLOSE: if (expire) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    dpw_ctrl_enc u_enc (
        .phase (st_d.phase),
        .rs    (st_d.rs),
        .ctrl  (ctrl_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.rs    <= 1'b1;
            st_q.held  <= '0;
            st_q.data  <= '0;
            st_q.done  <= 1'b0;
            ctrl_q     <= CTRL_RST;
        end else begin
            st_q   <= st_d;
            ctrl_q <= ctrl_d;
        end
    end

    assign req_ready = (st_q.phase == PH_IDLE);
    assign bus_data  = st_q.data;
    assign bus_cs_n  = ctrl_q.cs_n;
    assign bus_rd_n  = ctrl_q.rd_n;
    assign bus_wr_n  = ctrl_q.wr_n;
    assign bus_rs    = ctrl_q.rs;
    assign xfer_done = st_q.done;
endmodule

// File: rtl/dpw_port_chk.sv
module dpw_port_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic              xfer_done
);
    a_r4_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_n);

    a_r2_write_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr_n |-> !bus_cs_n);

    a_r7_busy_while_selected: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cs_n |-> !req_ready);

    a_r7_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r6_data_held_at_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> $stable(bus_data));

    a_r9_data_still_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && $past(req_ready)) |-> $stable(bus_data));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !xfer_done);

    a_r8_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (req_ready && $rose(req_ready)));
endmodule

bind dpw_port dpw_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_data  (bus_data),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .xfer_done (xfer_done)
);

// File: tb/tb_dpw_port.sv
module tb_dpw_port;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 3;
    localparam int NVEC       = 8;
    // bit 8 = parameter flag, bits 7:0 = byte
    localparam logic [8:0] VEC [NVEC] = '{9'h001, 9'h101, 9'h0E0, 9'h103,
                                          9'h0B0, 9'h1FF, 9'h100, 9'h055};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_byte = '0;
    logic       req_is_param = 1'b0;
    logic       req_ready, bus_cs_n, bus_rd_n, bus_wr_n, bus_rs, xfer_done;
    logic [7:0] bus_data;

    int n_run = 0;
    int n_fail = 0;
    logic [7:0] prev = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dpw_port #(.DATA_W(8), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_byte(req_byte), .req_is_param(req_is_param), .bus_data(bus_data),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_rs(bus_rs), .xfer_done(xfer_done)
    );

    function automatic logic [3:0] nib();
        return {bus_cs_n, bus_rd_n, bus_wr_n, bus_rs};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    task automatic check_reset_state(input string tag);
        chk({tag, " R1 ctrl"}, 32'(nib()), 32'hF);
        chk({tag, " R1 data"}, 32'(bus_data), 32'h0);
        chk({tag, " R1 ready"}, 32'(req_ready), 32'h1);
        chk({tag, " R1 done"}, 32'(xfer_done), 32'h0);
    endtask

    // One transfer; optional stray request while busy (R7)
    task automatic xfer(input logic p, input logic [7:0] b, input bit stray);
        logic [3:0] open_n, close_n;
        string rq;
        open_n  = {3'b010, p};
        close_n = {3'b111, p};
        rq      = p ? "R3" : "R2";
        @(negedge clk);
        chk("R7 ready before request", 32'(req_ready), 32'h1);
        req_valid = 1'b1; req_byte = b; req_is_param = p;
        @(negedge clk);
        req_valid = 1'b0; req_byte = 8'hXX ^ 8'h00; req_is_param = ~p;
        for (int k = 0; k <= 3*HOLD; k++) begin
            if (stray && k == HOLD) begin req_valid = 1'b1; req_byte = ~b; end
            if (stray && k == 2*HOLD) req_valid = 1'b0;
            chk("R4 read idle", 32'(bus_rd_n), 32'h1);
            if (k < HOLD) begin
                chk({rq, " open nibble"}, 32'(nib()), 32'(open_n));
                chk("R5 data unchanged in open step", 32'(bus_data), 32'(prev));
            end else if (k < 2*HOLD) begin
                chk({rq, " nibble in drive step"}, 32'(nib()), 32'(open_n));
                chk("R5 data driven", 32'(bus_data), 32'(b));
            end else begin
                chk({rq, " close nibble"}, 32'(nib()), 32'(close_n));
                chk("R6 data held at close", 32'(bus_data), 32'(b));
            end
            if (k < 3*HOLD) begin
                chk("R7 ready low while busy", 32'(req_ready), 32'h0);
                chk("R8 no early done", 32'(xfer_done), 32'h0);
            end else begin
                chk("R7 ready back", 32'(req_ready), 32'h1);
                chk("R8 done pulse", 32'(xfer_done), 32'h1);
            end
            if (k < 3*HOLD) @(negedge clk);
        end
        prev = b;
    endtask

    task automatic idle_check(input int n, input logic p);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R9 ctrl stays closed", 32'(nib()), 32'({3'b111, p}));
            chk("R9 R6 data kept", 32'(bus_data), 32'(prev));
            chk("R8 done low when idle", 32'(xfer_done), 32'h0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        #(CLK_PERIOD*2 + 2);
        check_reset_state("in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_state("after reset");

        // table-driven transfers
        for (int v = 0; v < NVEC; v++) begin
            xfer(VEC[v][8], VEC[v][7:0], 1'b0);
        end
        idle_check(4, VEC[NVEC-1][8]);

        // stray request while busy must be ignored (R7)
        xfer(1'b1, 8'h3A, 1'b1);
        idle_check(HOLD*3 + 2, 1'b1);
        chk("R7 stray request left ready high", 32'(req_ready), 32'h1);

        // index after parameter: register-select falls back (R2)
        xfer(1'b0, 8'hB6, 1'b0);
        idle_check(2, 1'b0);

        // reset in the middle of a transfer (R1)
        @(negedge clk);
        req_valid = 1'b1; req_byte = 8'hC3; req_is_param = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (HOLD + 1) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("mid-transfer reset");
        @(negedge clk);
        rst_n = 1'b1;
        prev = '0;
        @(negedge clk);
        check_reset_state("after second reset");
        xfer(1'b0, 8'h2C, 1'b0);

        finish_run();
    end
endmodule